// File: doc/BRIEF.md
# Bounded float round-to-integral unit

This unit takes one IEEE-754 binary32 or binary64 operand and rounds it to an integral floating-point value. It then checks that the integer fits in a signed 32-bit or 64-bit range. An operation code selects the target integer size. It also selects whether the rounding direction is forced toward zero or taken from a two-bit dynamic rounding-mode input. The result is returned in the same floating-point format as the operand, together with an invalid flag and an inexact flag.

A value that cannot be represented in the chosen range is rejected. This covers NaN, infinity and any finite value whose rounded magnitude exceeds the range. A rejected value returns the most negative integer of that size, encoded as a float, with invalid raised and inexact cleared. The datapath registers its inputs and then its result, and one operation may be issued every cycle.

Top module: `fp_rint_bounded`

## Requirements
- R1: A result appears with out_valid high exactly two rising clock edges after the edge that samples in_valid high. Back-to-back inputs give back-to-back results in issue order, and reset clears out_valid.
- R2: in_op[1] selects the integer size N (0 gives 32, 1 gives 64). in_op[0] = 0 forces round toward zero, and in_op[0] = 1 uses in_rmode. The in_rmode encoding is 0 = nearest-even, 1 = toward +infinity, 2 = toward -infinity, 3 = toward zero.
- R3: An operand whose biased exponent is all ones (NaN or infinity) is always rejected.
- R4: A rounded value is accepted when its biased exponent is below bias-1+N. At exactly bias-1+N it is accepted only when it is negative with a zero fraction, which is -2^(N-1); any other value there, and any value above, is rejected.
- R5: A rejected value produces sign 1, biased exponent bias-1+N and fraction 0, with invalid = 1 and inexact = 0, even if rounding discarded nonzero bits.
- R6: An accepted value produces the rounded integral value with invalid = 0, and inexact = 1 exactly when rounding changed the value.
- R7: A nonzero operand of magnitude below 1, subnormals included, rounds to a zero or a one that keeps its sign, as the rounding direction decides, and raises inexact.
- R8: An operand that is already integral (biased exponent at least bias plus fraction width), or a zero of either sign, passes through unchanged without inexact.
- R9: With in_dbl = 0 only in_operand[31:0] is used, and the result occupies out_result[31:0] with bits 63:32 zero. With in_dbl = 1 all 64 bits are used.
- R10: In nearest-even mode an exact halfway value rounds to the even integer, so 0.5 rounds to 0, 2.5 to 2 and 3.5 to 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand present this cycle |
| in_operand | input | 64 | Operand bits; binary32 in bits 31:0 |
| in_dbl | input | 1 | 1 = binary64 operand, 0 = binary32 |
| in_op | input | 2 | Bit 1: integer size 64; bit 0: use dynamic rounding mode |
| in_rmode | input | 2 | Dynamic rounding mode |
| out_valid | output | 1 | Result present this cycle |
| out_result | output | 64 | Integral floating-point result |
| out_invalid | output | 1 | Value was NaN, infinity or out of range |
| out_inexact | output | 1 | Accepted result differs from the operand |

## Verification
The following are checked on every cycle:
- The two-edge spacing between in_valid and out_valid.
- That a rejected result never carries inexact and always equals the minimum-integer encoding for the size and format that were issued.
- That NaN and infinity operands always come back rejected.
- That binary32 results leave the upper half zero.

Only the bench scenarios can show that the rounded value is right in each direction, including ties to even, tiny and subnormal operands and carries into the exponent. The same applies to the exact boundary at -2^(N-1) against its positive twin, and to inexact being dropped when an inexact rounding lands out of range.

// File: rtl/fprb_pkg.sv
package fprb_pkg;

   typedef enum logic [1:0] {
      RND_NEAR_EVEN = 2'd0,
      RND_UP        = 2'd1,
      RND_DOWN      = 2'd2,
      RND_ZERO      = 2'd3
   } rnd_mode_e;

   localparam int FMT_COUNT = 2;

endpackage

// File: rtl/fprb_round.sv
module fprb_round
   import fprb_pkg::*;
#(
   parameter int  EXP_W  = 8,
   parameter int  FRAC_W = 23,
   localparam int W      = 1 + EXP_W + FRAC_W
) (
   input  logic [W-1:0] in_word,
   input  rnd_mode_e    mode,
   output logic [W-1:0] rnd_word,
   output logic         rnd_inexact,
   output logic         special
);

   localparam int BIAS = (1 << (EXP_W - 1)) - 1;
   localparam int MW   = FRAC_W + 2;
   localparam int SH_W = $clog2(FRAC_W + 1);

   logic              sgn;
   logic [EXP_W-1:0]  e;
   logic [FRAC_W-1:0] frac;
   logic              big, tiny, zero_in;
   logic [SH_W-1:0]   fsh;
   logic [MW-1:0]     mant, one_f, mask, rem, intp, half, sum;
   logic              lsb_set, frac_nz, up, tiny_one, carry;
   logic              unused_hidden;

   always_comb begin
      sgn     = in_word[W-1];
      e       = in_word[W-2:FRAC_W];
      frac    = in_word[FRAC_W-1:0];
      special = &e;
      zero_in = (e == '0) && (frac == '0);
      big     = {1'b0, e} >= (EXP_W+1)'(BIAS + FRAC_W);
      tiny    = {1'b0, e} <  (EXP_W+1)'(BIAS);

      fsh     = SH_W'((EXP_W+1)'(BIAS + FRAC_W) - {1'b0, e});
      mant    = {2'b01, frac};
      one_f   = MW'(1) << fsh;
      mask    = one_f - MW'(1);
      rem     = mant & mask;
      intp    = mant & ~mask;
      half    = one_f >> 1;
      lsb_set = |(mant & one_f);
      frac_nz = rem != '0;

      unique case (mode)
         RND_NEAR_EVEN: up = (rem > half) || ((rem == half) && lsb_set);
         RND_UP:        up = frac_nz && !sgn;
         RND_DOWN:      up = frac_nz && sgn;
         default:       up = 1'b0;
      endcase

      unique case (mode)
         RND_NEAR_EVEN: tiny_one = (e == EXP_W'(BIAS - 1)) && (frac != '0);
         RND_UP:        tiny_one = !sgn;
         RND_DOWN:      tiny_one = sgn;
         default:       tiny_one = 1'b0;
      endcase

      sum           = intp + (up ? one_f : '0);
      carry         = sum[MW-1];
      unused_hidden = sum[FRAC_W];

      if (special || big || zero_in) begin
         rnd_word    = in_word;
         rnd_inexact = 1'b0;
      end else if (tiny) begin
         rnd_word    = {sgn, (tiny_one ? EXP_W'(BIAS) : EXP_W'(0)), FRAC_W'(0)};
         rnd_inexact = 1'b1;
      end else begin
         rnd_word    = {sgn, e + EXP_W'(carry), (carry ? FRAC_W'(0) : sum[FRAC_W-1:0])};
         rnd_inexact = frac_nz;
      end
   end

endmodule

// File: rtl/fprb_bound.sv
module fprb_bound #(
   parameter int  EXP_W  = 8,
   parameter int  FRAC_W = 23,
   localparam int W      = 1 + EXP_W + FRAC_W
) (
   input  logic [W-1:0] rnd_word,
   input  logic         rnd_inexact,
   input  logic         special,
   input  logic         size64,
   output logic [W-1:0] res_word,
   output logic         res_invalid,
   output logic         res_inexact
);

   localparam int BIAS = (1 << (EXP_W - 1)) - 1;
   localparam logic [EXP_W-1:0] LIM32 = EXP_W'(BIAS - 1 + 32);
   localparam logic [EXP_W-1:0] LIM64 = EXP_W'(BIAS - 1 + 64);

   logic [EXP_W-1:0] limit;
   logic [EXP_W-1:0] re;
   logic             at_min, fits;

   always_comb begin
      limit       = size64 ? LIM64 : LIM32;
      re          = rnd_word[W-2:FRAC_W];
      at_min      = (re == limit) && rnd_word[W-1] && (rnd_word[FRAC_W-1:0] == '0);
      fits        = !special && ((re < limit) || at_min);
      res_word    = fits ? rnd_word : {1'b1, limit, FRAC_W'(0)};
      res_invalid = !fits;
      res_inexact = fits && rnd_inexact;
   end

endmodule

// File: rtl/fp_rint_bounded.sv
module fp_rint_bounded
   import fprb_pkg::*;
#(
   parameter int  SP_EXP_W  = 8,
   parameter int  SP_FRAC_W = 23,
   parameter int  DP_EXP_W  = 11,
   parameter int  DP_FRAC_W = 52,
   parameter int  DATA_W    = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_operand,
   input  logic              in_dbl,
   input  logic [1:0]        in_op,
   input  logic [1:0]        in_rmode,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_result,
   output logic              out_invalid,
   output logic              out_inexact
);

   localparam int SP_W = 1 + SP_EXP_W + SP_FRAC_W;
   localparam int DP_W = 1 + DP_EXP_W + DP_FRAC_W;

   if (DATA_W < DP_W || SP_W >= DP_W) begin : g_bad_width
      $error("fp_rint_bounded: format widths do not fit DATA_W");
   end
   if ((1 << (SP_EXP_W - 1)) - 2 + 64 >= (1 << SP_EXP_W) - 1) begin : g_bad_sp_range
      $error("fp_rint_bounded: single exponent too narrow for 64-bit bound");
   end
   if ((1 << (DP_EXP_W - 1)) - 2 + 64 >= (1 << DP_EXP_W) - 1) begin : g_bad_dp_range
      $error("fp_rint_bounded: double exponent too narrow for 64-bit bound");
   end

   // Input register stage
   logic              s1_valid;
   logic [DATA_W-1:0] s1_operand;
   logic              s1_dbl;
   logic              s1_size64;
   rnd_mode_e         s1_mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) s1_valid <= 1'b0;
      else        s1_valid <= in_valid;
   end

   always_ff @(posedge clk) begin
      if (in_valid) begin
         s1_operand <= in_operand;
         s1_dbl     <= in_dbl;
         s1_size64  <= in_op[1];
         s1_mode    <= in_op[0] ? rnd_mode_e'(in_rmode) : RND_ZERO;
      end
   end

   // One lane per format
   logic [DATA_W-1:0] lane_res [FMT_COUNT];
   logic              lane_inv [FMT_COUNT];
   logic              lane_inx [FMT_COUNT];

   for (genvar g = 0; g < FMT_COUNT; g++) begin : g_fmt
      localparam int EW = (g == 0) ? SP_EXP_W  : DP_EXP_W;
      localparam int FW = (g == 0) ? SP_FRAC_W : DP_FRAC_W;
      localparam int LW = 1 + EW + FW;

      logic [LW-1:0] rnd_word, res_word;
      logic          rnd_inexact, special;

      fprb_round #(.EXP_W(EW), .FRAC_W(FW)) u_round (
         .in_word     (s1_operand[LW-1:0]),
         .mode        (s1_mode),
         .rnd_word    (rnd_word),
         .rnd_inexact (rnd_inexact),
         .special     (special)
      );

      fprb_bound #(.EXP_W(EW), .FRAC_W(FW)) u_bound (
         .rnd_word    (rnd_word),
         .rnd_inexact (rnd_inexact),
         .special     (special),
         .size64      (s1_size64),
         .res_word    (res_word),
         .res_invalid (lane_inv[g]),
         .res_inexact (lane_inx[g])
      );

      if (LW < DATA_W) begin : g_pad
         assign lane_res[g] = {{(DATA_W-LW){1'b0}}, res_word};
      end else begin : g_full
         assign lane_res[g] = res_word;
      end
   end

   // Result register stage
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_valid <= 1'b0;
      else        out_valid <= s1_valid;
   end

   always_ff @(posedge clk) begin
      if (s1_valid) begin
         out_result  <= lane_res[s1_dbl];
         out_invalid <= lane_inv[s1_dbl];
         out_inexact <= lane_inx[s1_dbl];
      end
   end

endmodule

// File: rtl/fprb_chk.sv
module fprb_chk #(
   parameter int SP_EXP_W  = 8,
   parameter int SP_FRAC_W = 23,
   parameter int DP_EXP_W  = 11,
   parameter int DP_FRAC_W = 52,
   parameter int DATA_W    = 64
) (
   input logic                clk,
   input logic                rst_n,
   input logic                in_valid,
   input logic                in_dbl,
   input logic                in_size64,
   input logic [SP_EXP_W-1:0] in_sp_exp,
   input logic [DP_EXP_W-1:0] in_dp_exp,
   input logic                out_valid,
   input logic [DATA_W-1:0]   out_result,
   input logic                out_invalid,
   input logic                out_inexact
);

   localparam int SP_W    = 1 + SP_EXP_W + SP_FRAC_W;
   localparam int DP_W    = 1 + DP_EXP_W + DP_FRAC_W;
   localparam int SP_BIAS = (1 << (SP_EXP_W - 1)) - 1;
   localparam int DP_BIAS = (1 << (DP_EXP_W - 1)) - 1;

   function automatic logic [DATA_W-1:0] min_code(input logic dbl, input logic s64);
      int n;
      n = s64 ? 64 : 32;
      if (dbl)
         return (DATA_W'(1) << (DP_W - 1)) | (DATA_W'(DP_BIAS - 1 + n) << DP_FRAC_W);
      else
         return (DATA_W'(1) << (SP_W - 1)) | (DATA_W'(SP_BIAS - 1 + n) << SP_FRAC_W);
   endfunction

   logic [1:0] seen;
   logic       hist_ok;
   logic       in_special;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             seen <= 2'd0;
      else if (seen != 2'd2)  seen <= seen + 2'd1;
   end

   assign hist_ok    = seen == 2'd2;
   assign in_special = in_dbl ? (&in_dp_exp) : (&in_sp_exp);

   AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      hist_ok |-> (out_valid == $past(in_valid, 2)));                        // R1

   AST_REJECT_NO_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_invalid) |-> !out_inexact);                          // R5

   AST_REJECT_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      (hist_ok && out_valid && out_invalid) |->
         (out_result == min_code($past(in_dbl, 2), $past(in_size64, 2))));   // R5

   AST_SPECIAL_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
      (hist_ok && out_valid && $past(in_special, 2)) |-> out_invalid);       // R3

   AST_SINGLE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (hist_ok && out_valid && !$past(in_dbl, 2)) |->
         (out_result[DATA_W-1:SP_W] == '0));                                 // R9

endmodule

bind fp_rint_bounded fprb_chk #(
   .SP_EXP_W  (SP_EXP_W),
   .SP_FRAC_W (SP_FRAC_W),
   .DP_EXP_W  (DP_EXP_W),
   .DP_FRAC_W (DP_FRAC_W),
   .DATA_W    (DATA_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .in_dbl      (in_dbl),
   .in_size64   (in_op[1]),
   .in_sp_exp   (in_operand[SP_EXP_W+SP_FRAC_W-1:SP_FRAC_W]),
   .in_dp_exp   (in_operand[DP_EXP_W+DP_FRAC_W-1:DP_FRAC_W]),
   .out_valid   (out_valid),
   .out_result  (out_result),
   .out_invalid (out_invalid),
   .out_inexact (out_inexact)
);

// File: tb/sim_fp_rint_bounded.sv
`timescale 1ns/1ps
module sim_fp_rint_bounded;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [63:0] in_operand = '0;
   logic        in_dbl = 1'b0;
   logic [1:0]  in_op = 2'd0;
   logic [1:0]  in_rmode = 2'd0;
   logic        out_valid;
   logic [63:0] out_result;
   logic        out_invalid;
   logic        out_inexact;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   bit finished = 0;

   logic [63:0] q_res[$];
   logic        q_inv[$];
   logic        q_inx[$];
   int          q_cyc[$];
   string       q_tag[$];

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   fp_rint_bounded u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_operand(in_operand),
      .in_dbl(in_dbl), .in_op(in_op), .in_rmode(in_rmode), .out_valid(out_valid),
      .out_result(out_result), .out_invalid(out_invalid), .out_inexact(out_inexact)
   );

   task automatic send(input logic [63:0] opnd, input logic dbl, input logic [1:0] op,
                       input logic [1:0] rm, input logic [63:0] er, input logic ei,
                       input logic ex, input string tag);
      @(negedge clk);
      in_valid = 1'b1; in_operand = opnd; in_dbl = dbl; in_op = op; in_rmode = rm;
      q_res.push_back(er); q_inv.push_back(ei); q_inx.push_back(ex);
      q_cyc.push_back(cyc); q_tag.push_back(tag);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0; in_operand = 64'hFFFF_FFFF_FFFF_FFFF;
      end
   endtask

   // Monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         checks++;
         if (q_res.size() == 0) begin
            failures++;
            $display("FAIL R1 unexpected result %h (expected none)", out_result);
         end else begin
            logic [63:0] er; logic ei, ex; int ic; string t;
            er = q_res.pop_front(); ei = q_inv.pop_front(); ex = q_inx.pop_front();
            ic = q_cyc.pop_front(); t = q_tag.pop_front();
            if (out_result !== er || out_invalid !== ei || out_inexact !== ex) begin
               failures++;
               $display("FAIL %s result=%h inv=%b inx=%b expected result=%h inv=%b inx=%b",
                        t, out_result, out_invalid, out_inexact, er, ei, ex);
            end
            checks++;
            if (cyc - ic != 2) begin
               failures++;
               $display("FAIL R1 latency=%0d expected=2", cyc - ic);
            end
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0) begin
         failures++;
         $display("FAIL R1 out_valid after reset=%b expected=0", out_valid);
      end

      // R10 ties to even, R6 rounded values
      send(64'h40200000, 0, 2'd1, 2'd0, 64'h40000000, 0, 1, "R10 2.5 nearest");
      send(64'h40600000, 0, 2'd1, 2'd0, 64'h40800000, 0, 1, "R10 3.5 nearest");
      send(64'h3F000000, 0, 2'd1, 2'd0, 64'h00000000, 0, 1, "R10 0.5 nearest");
      send(64'h3F400000, 0, 2'd1, 2'd0, 64'h3F800000, 0, 1, "R7 0.75 nearest");
      // R2 forced toward zero ignores in_rmode
      send(64'h40600000, 0, 2'd0, 2'd1, 64'h40400000, 0, 1, "R2 3.5 forced zero");
      send(64'h40200000, 0, 2'd1, 2'd1, 64'h40400000, 0, 1, "R6 2.5 up");
      send(64'hC0200000, 0, 2'd1, 2'd2, 64'hC0400000, 0, 1, "R6 -2.5 down");
      send(64'hC0200000, 0, 2'd1, 2'd1, 64'hC0000000, 0, 1, "R6 -2.5 up");
      send(64'h40600000, 0, 2'd1, 2'd3, 64'h40400000, 0, 1, "R2 3.5 dynamic zero");
      idle(2);
      // R7 tiny and subnormal
      send(64'h3E99999A, 0, 2'd1, 2'd1, 64'h3F800000, 0, 1, "R7 0.3 up");
      send(64'hBE99999A, 0, 2'd1, 2'd1, 64'h80000000, 0, 1, "R7 -0.3 up");
      send(64'hBE99999A, 0, 2'd1, 2'd2, 64'hBF800000, 0, 1, "R7 -0.3 down");
      send(64'h00000001, 0, 2'd1, 2'd1, 64'h3F800000, 0, 1, "R7 subnormal up");
      send(64'h00000001, 0, 2'd1, 2'd0, 64'h00000000, 0, 1, "R7 subnormal nearest");
      // R8 pass-through
      send(64'h80000000, 0, 2'd1, 2'd1, 64'h80000000, 0, 0, "R8 minus zero");
      send(64'h40A00000, 0, 2'd1, 2'd0, 64'h40A00000, 0, 0, "R8 5.0");
      send(64'h4E800000, 0, 2'd1, 2'd0, 64'h4E800000, 0, 0, "R8 2^30");
      idle(1);
      // R3 specials, R5 reject encoding
      send(64'h7FC00000, 0, 2'd1, 2'd0, 64'hCF000000, 1, 0, "R3 NaN N=32");
      send(64'h7F800000, 0, 2'd2, 2'd0, 64'hDF000000, 1, 0, "R3 inf N=64");
      send(64'h7FF0000000000000, 1, 2'd0, 2'd0, 64'hC1E0000000000000, 1, 0, "R3 double inf");
      // R4 boundary
      send(64'h4F000000, 0, 2'd0, 2'd0, 64'hCF000000, 1, 0, "R4 +2^31 N=32");
      send(64'hCF000000, 0, 2'd0, 2'd0, 64'hCF000000, 0, 0, "R4 -2^31 N=32");
      send(64'h4F000000, 0, 2'd2, 2'd0, 64'h4F000000, 0, 0, "R2 +2^31 N=64");
      send(64'hC1E0000000100000, 1, 2'd0, 2'd0, 64'hC1E0000000000000, 0, 1, "R4 -2^31-0.5 zero");
      send(64'hC1E0000000200000, 1, 2'd0, 2'd0, 64'hC1E0000000000000, 1, 0, "R4 -2^31-1");
      send(64'hC3E0000000000000, 1, 2'd2, 2'd0, 64'hC3E0000000000000, 0, 0, "R4 -2^63 N=64");
      send(64'h43E0000000000000, 1, 2'd3, 2'd0, 64'hC3E0000000000000, 1, 0, "R4 +2^63 N=64");
      // R5 inexact suppressed on reject
      send(64'h41EFFFFFFFF00000, 1, 2'd1, 2'd0, 64'hC1E0000000000000, 1, 0, "R5 2^32-0.5 nearest");
      send(64'h41EFFFFFFFF00000, 1, 2'd0, 2'd0, 64'hC1E0000000000000, 1, 0, "R5 2^32-0.5 zero");
      // R9 format selection
      send(64'h4004000000000000, 1, 2'd1, 2'd0, 64'h4000000000000000, 0, 1, "R9 double 2.5");
      send(64'hDEADBEEF40200000, 0, 2'd1, 2'd0, 64'h0000000040000000, 0, 1, "R9 single upper junk");
      idle(6);

      checks++;
      if (q_res.size() != 0) begin
         failures++;
         $display("FAIL R1 pending=%0d expected=0", q_res.size());
      end
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #(4 * 20000);
      if (!finished) begin
         finished = 1;
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule